// File: doc/BRIEF.md
# Audio Processor Interval Timer and Control Unit

This block holds the control byte of a small audio processor's I/O page and three programmable interval timers. The processor writes bytes to an 8-bit address space. One address holds the control byte, three addresses hold the timer periods, and three more addresses, when read, return each timer's 4-bit event counter. Reading a counter also clears it.

A separate prescaler supplies each timer with its own one-cycle tick enable. While a timer is enabled, each tick advances its internal count. When the count reaches the programmed period, the count restarts at zero and the event counter goes up by one. The control byte also produces one-cycle clear pulses for the four host input ports. It drives a select line that makes a 64-byte boot ROM or RAM visible at the top of memory.

Top module: `audio_timer_unit`

## Requirements
- R1: After synchronous reset, the control byte is 0x80. This means boot_rom_sel is 1, port_clr is 0, all three timers are disabled, and every event counter reads 0.
- R2: A write to address 0xF1 stores the whole control byte. Bits 0, 1 and 2 enable timers 0, 1 and 2.
- R3: A write to address 0xFA, 0xFB or 0xFC sets the period of timer 0, 1 or 2. The new period applies from the next tick onward.
- R4: A period value of 0 means 256 ticks per event.
- R5: On each tick of an enabled timer, its 8-bit count goes up by one. When count+1 equals the period, the count becomes 0 and the 4-bit event counter goes up by one. The event counter wraps from 15 to 0.
- R6: A control write that changes a timer's enable from 0 to 1 clears that timer's count and event counter. Writing 1 to a timer that is already enabled leaves its state unchanged.
- R7: A disabled timer ignores its tick. Its count and event counter hold their values, and the event counter stays readable.
- R8: A read with rd_en at 0xFD, 0xFE or 0xFF returns the event counter of timer 0, 1 or 2 in the same cycle, in bits 3:0 with bits 7:4 at zero. The counter clears at that clock edge. If an event coincides with the read, the counter becomes 1. A read at any other address returns 0.
- R9: A control write with bit 4 set pulses port_clr[1:0] high for the following cycle. A control write with bit 5 set does the same for port_clr[3:2]. At all other times port_clr is 0.
- R10: boot_rom_sel equals bit 7 of the last control byte written.
- R11: If the period is lowered below the current count, the count keeps rising to 255 and rolls over to 0 without an event. It then counts toward the new period.
- R12: Timer i advances only on tick[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; reading an event counter clears it |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| tick | input | 3 | Per-timer tick enables from the prescaler |
| port_clr | output | 4 | One-cycle clear pulses for the host input ports |
| boot_rom_sel | output | 1 | 1 selects boot ROM at the top 64 bytes, 0 selects RAM |

## Verification
Random traffic mixes control writes with arbitrary bytes, short periods, reads of all seven relevant addresses and independent tick patterns. This separates per-timer tick routing, enable edge detection and read-clear priority from the plain counting path. Directed sequences cover what random traffic rarely reaches: a full 256-tick period from a zero target, a period lowered below the running count, a read that coincides with an event, and a repeated enable on a running timer. Each case has an exact expected event count that differs from what a faulty wrap, clear or compare would give.

// File: rtl/atcu_pkg.sv
// Package: shared bit positions and reset values of the timer control unit.
// Assumes an 8-bit control byte; positions are fixed by software decoding.
package atcu_pkg;
    localparam int          CTRL_W        = 8;
    localparam int          CLR_LO_BIT    = 4;      // clears ports 0 and 1
    localparam int          CLR_HI_BIT    = 5;      // clears ports 2 and 3
    localparam int          ROM_SEL_BIT   = 7;      // boot ROM visible
    localparam logic [7:0]  CTRL_RST_VAL  = 8'h80;
endpackage

// File: rtl/atcu_ctrl_reg.sv
// Control byte register. Stores the byte written to the control address,
// derives per-timer enables and their 0-to-1 edges, the one-cycle port clear
// pulses and the boot ROM select. Assumes N_PORT is even: the lower half of
// the ports clears with one bit, the upper half with the other.
module atcu_ctrl_reg
    import atcu_pkg::*;
#(
    parameter int N_TMR  = 3,
    parameter int N_PORT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [N_TMR-1:0]  tmr_en,
    output logic [N_TMR-1:0]  tmr_rise,
    output logic [N_PORT-1:0] port_clr,
    output logic              boot_rom_sel
);
    localparam int HALF = N_PORT / 2;

    // Purpose: hold the control byte, reset to boot ROM visible.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST_VAL;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Purpose: per-timer enable and its rising edge caused by this write.
    always_comb begin
        tmr_en   = ctrl_q[N_TMR-1:0];
        tmr_rise = {N_TMR{ctrl_we}} & ctrl_wdata[N_TMR-1:0] & ~ctrl_q[N_TMR-1:0];
    end

    // Purpose: one-cycle clear pulse per port, registered after the write.
    genvar p;
    generate
        for (p = 0; p < N_PORT; p++) begin : g_clr
            localparam int SRC_BIT = (p < HALF) ? CLR_LO_BIT : CLR_HI_BIT;
            always_ff @(posedge clk) begin
                if (!rst_n) port_clr[p] <= 1'b0;
                else        port_clr[p] <= ctrl_we & ctrl_wdata[SRC_BIT];
            end
        end
    endgenerate

    // Purpose: memory overlay select follows the stored bit.
    assign boot_rom_sel = ctrl_q[ROM_SEL_BIT];
endmodule

// File: rtl/atcu_timer.sv
// One interval timer channel. Holds its period register, an internal count
// and a small event counter. A zero period means 2**CNT_W ticks. An enable
// edge clears the state; a read clear empties the event counter but keeps an
// event that lands in the same cycle. Assumes CNT_W <= DATA_W.
module atcu_timer #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int OUT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              en_rise,
    input  logic              tgt_we,
    input  logic [DATA_W-1:0] tgt_wdata,
    input  logic              rd_clr,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [OUT_W-1:0]  out_q
);
    localparam int PW = CNT_W + 1;

    logic [CNT_W-1:0] cmp_q;
    logic [PW-1:0]    period;
    logic [PW-1:0]    cnt_inc;
    logic             step;
    logic             hit;

    // Purpose: period register, written straight from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (tgt_we) cmp_q <= tgt_wdata[CNT_W-1:0];
    end

    // Purpose: effective period and the compare of the next count.
    always_comb begin
        period  = (cmp_q == '0) ? PW'(1 << CNT_W) : {1'b0, cmp_q};
        cnt_inc = {1'b0, cnt_q} + PW'(1);
        step    = en & tick;
        hit     = step & (cnt_inc == period);
    end

    // Purpose: internal count, cleared on enable edge, frozen when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (en_rise) cnt_q <= '0;
        else if (hit)     cnt_q <= '0;
        else if (step)    cnt_q <= cnt_inc[CNT_W-1:0];
    end

    // Purpose: event counter with read clear that keeps a coincident event.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (en_rise) out_q <= '0;
        else if (rd_clr)  out_q <= OUT_W'(hit);
        else if (hit)     out_q <= out_q + OUT_W'(1);
    end
endmodule

// File: rtl/atcu_rd_mux.sv
// Read port multiplexer. Returns the event counter addressed by rd_addr,
// zero-extended to the data width, or zero for any other address.
// Assumes the counter addresses are consecutive from OUT_BASE.
module atcu_rd_mux #(
    parameter int                 N_TMR    = 3,
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 8,
    parameter int                 OUT_W    = 4,
    parameter logic [ADDR_W-1:0]  OUT_BASE = 'hFD
) (
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [N_TMR-1:0][OUT_W-1:0] out_all,
    output logic [DATA_W-1:0]           rd_data
);
    // Purpose: select the addressed counter; other addresses read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (rd_en && rd_addr == ADDR_W'(OUT_BASE + i))
                rd_data = DATA_W'(out_all[i]);
        end
    end
endmodule

// File: rtl/audio_timer_unit.sv
// Top of the audio processor timer and control unit. Decodes byte writes to
// the control and period addresses and reads of the event counters, and
// instantiates one timer channel per tick input. Assumes tick[i] is a
// one-cycle enable from an external prescaler in the same clock domain.
module audio_timer_unit
    import atcu_pkg::*;
#(
    parameter int                 N_TMR     = 3,
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 8,
    parameter int                 CNT_W     = 8,
    parameter int                 OUT_W     = 4,
    parameter int                 N_PORT    = 4,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 'hF1,
    parameter logic [ADDR_W-1:0]  TGT_BASE  = 'hFA,
    parameter logic [ADDR_W-1:0]  OUT_BASE  = 'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_TMR-1:0]  tick,
    output logic [N_PORT-1:0] port_clr,
    output logic              boot_rom_sel
);
    logic                        ctrl_we;
    logic [CTRL_W-1:0]           ctrl_q;
    logic [N_TMR-1:0]            tmr_en;
    logic [N_TMR-1:0]            tmr_rise;
    logic [N_TMR-1:0]            tgt_we;
    logic [N_TMR-1:0]            rd_clr;
    logic [N_TMR-1:0][CNT_W-1:0] cnt_all;
    logic [N_TMR-1:0][OUT_W-1:0] out_all;

    // Purpose: control address decode.
    assign ctrl_we = wr_en && (wr_addr == CTRL_ADDR);

    atcu_ctrl_reg #(
        .N_TMR  (N_TMR),
        .N_PORT (N_PORT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (wr_data[CTRL_W-1:0]),
        .ctrl_q       (ctrl_q),
        .tmr_en       (tmr_en),
        .tmr_rise     (tmr_rise),
        .port_clr     (port_clr),
        .boot_rom_sel (boot_rom_sel)
    );

    genvar i;
    generate
        for (i = 0; i < N_TMR; i++) begin : g_tmr
            // Purpose: per-channel period write and counter read decode.
            assign tgt_we[i] = wr_en && (wr_addr == ADDR_W'(TGT_BASE + i));
            assign rd_clr[i] = rd_en && (rd_addr == ADDR_W'(OUT_BASE + i));

            atcu_timer #(
                .DATA_W (DATA_W),
                .CNT_W  (CNT_W),
                .OUT_W  (OUT_W)
            ) u_tmr (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick[i]),
                .en        (tmr_en[i]),
                .en_rise   (tmr_rise[i]),
                .tgt_we    (tgt_we[i]),
                .tgt_wdata (wr_data),
                .rd_clr    (rd_clr[i]),
                .cnt_q     (cnt_all[i]),
                .out_q     (out_all[i])
            );
        end
    endgenerate

    atcu_rd_mux #(
        .N_TMR    (N_TMR),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .OUT_W    (OUT_W),
        .OUT_BASE (OUT_BASE)
    ) u_rd (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .out_all (out_all),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/atcu_checker.sv
// Assertion checker for the timer control unit, bound into the top module.
// Observes the ports plus the control byte and per-channel counters.
module atcu_checker #(
    parameter int                 N_TMR     = 3,
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 8,
    parameter int                 CNT_W     = 8,
    parameter int                 OUT_W     = 4,
    parameter int                 N_PORT    = 4,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 'hF1,
    parameter logic [ADDR_W-1:0]  OUT_BASE  = 'hFD
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic                        rd_en,
    input logic [ADDR_W-1:0]           rd_addr,
    input logic [DATA_W-1:0]           rd_data,
    input logic [N_TMR-1:0]            tick,
    input logic [N_PORT-1:0]           port_clr,
    input logic                        boot_rom_sel,
    input logic [7:0]                  ctrl_q,
    input logic [N_TMR-1:0][CNT_W-1:0] cnt_all,
    input logic [N_TMR-1:0][OUT_W-1:0] out_all
);
    logic cw;
    assign cw = wr_en && (wr_addr == CTRL_ADDR);

    // R1: first cycle out of reset shows the boot ROM selected
    assert_rst_rom_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (boot_rom_sel && port_clr == '0));

    // R9: clear pulses follow the control write bits
    assert_clr_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wr_data[4]) |=> (port_clr[1:0] == 2'b11));
    assert_clr_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wr_data[5]) |=> (port_clr[3:2] == 2'b11));
    assert_clr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cw |=> (port_clr == '0));

    // R10: select follows bit 7 of a control write, else holds
    assert_rom_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (boot_rom_sel == $past(wr_data[7])));
    assert_rom_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cw |=> $stable(boot_rom_sel));

    // R8: upper read bits are always zero
    assert_rd_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:OUT_W] == '0);

    genvar i;
    generate
        for (i = 0; i < N_TMR; i++) begin : g_chk
            logic hit_rd;
            assign hit_rd = rd_en && (rd_addr == ADDR_W'(OUT_BASE + i));

            // R8: a read without a tick leaves the counter empty
            assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_rd && !tick[i]) |=> (out_all[i] == '0));

            // R6: an enable edge clears count and counter
            assert_en_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cw && wr_data[i] && !ctrl_q[i]) |=> (cnt_all[i] == '0 && out_all[i] == '0));

            // R7: a disabled timer holds its state
            assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_q[i] && !cw && !hit_rd) |=> ($stable(cnt_all[i]) && $stable(out_all[i])));

            // R12: without its own tick a timer's count holds
            assert_own_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (!tick[i] && !cw) |=> $stable(cnt_all[i]));
        end
    endgenerate
endmodule

bind audio_timer_unit atcu_checker #(
    .N_TMR     (N_TMR),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .OUT_W     (OUT_W),
    .N_PORT    (N_PORT),
    .CTRL_ADDR (CTRL_ADDR),
    .OUT_BASE  (OUT_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .tick         (tick),
    .port_clr     (port_clr),
    .boot_rom_sel (boot_rom_sel),
    .ctrl_q       (ctrl_q),
    .cnt_all      (cnt_all),
    .out_all      (out_all)
);

// File: tb/audio_timer_unit_tb.sv
`timescale 1ns/1ps
module audio_timer_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] tick = '0;
    logic [3:0] port_clr;
    logic       boot_rom_sel;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // reference state, built from the requirements
    logic [7:0] m_ctrl;
    logic [7:0] m_tgt [3];
    logic [7:0] m_cnt [3];
    logic [3:0] m_out [3];
    logic [3:0] m_clr;

    always #2.5 clk = ~clk;

    audio_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .port_clr(port_clr), .boot_rom_sel(boot_rom_sel)
    );

    function automatic int period_of(logic [7:0] t);
        return (t == 8'd0) ? 256 : int'(t);
    endfunction

    function automatic logic [7:0] read_value(logic re, logic [7:0] a);
        if (re && a >= 8'hFD) return {4'h0, m_out[a - 8'hFD]};
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // advance the reference by one clock edge with the given inputs
    task automatic model_step(logic we, logic [7:0] wa, logic [7:0] wd,
                              logic re, logic [7:0] ra, logic [2:0] tk);
        for (int i = 0; i < 3; i++) begin
            logic inc = 1'b0;
            logic rh  = re && (ra == 8'(8'hFD + i));
            if (m_ctrl[i] && tk[i]) begin
                int n = int'(m_cnt[i]) + 1;
                if (n == period_of(m_tgt[i])) begin m_cnt[i] = 8'd0; inc = 1'b1; end
                else m_cnt[i] = 8'(n);
            end
            m_out[i] = rh ? {3'b000, inc} : m_out[i] + {3'b000, inc};
            if (we && wa == 8'(8'hFA + i)) m_tgt[i] = wd;
            if (we && wa == 8'hF1 && wd[i] && !m_ctrl[i]) begin
                m_cnt[i] = 8'd0; m_out[i] = 4'd0;
            end
        end
        m_clr = (we && wa == 8'hF1) ? {wd[5], wd[5], wd[4], wd[4]} : 4'b0000;
        if (we && wa == 8'hF1) m_ctrl = wd;
    endtask

    // one bus cycle: drive, check the read, clock, check registered outputs
    task automatic cyc(logic we, logic [7:0] wa, logic [7:0] wd,
                       logic re, logic [7:0] ra, logic [2:0] tk, string req);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; tick = tk;
        #1;
        if (re) check(req, 32'(rd_data), 32'(read_value(re, ra)));
        model_step(we, wa, wd, re, ra, tk);
        @(posedge clk); #1;
        check("R9", 32'(port_clr), 32'(m_clr));
        check("R10", 32'(boot_rom_sel), 32'(m_ctrl[7]));
        wr_en = 1'b0; rd_en = 1'b0; tick = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string req);
        cyc(1'b1, a, d, 1'b0, 8'h00, 3'b000, req);
    endtask

    task automatic rd(logic [7:0] a, string req);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, a, 3'b000, req);
    endtask

    task automatic ticks(int n, logic [2:0] tk);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 8'h00, 1'b0, 8'h00, tk, "R5");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_ctrl = 8'h80; m_clr = '0;
        for (int i = 0; i < 3; i++) begin m_tgt[i] = '0; m_cnt[i] = '0; m_out[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", 32'(boot_rom_sel), 32'd1);
        check("R1", 32'(port_clr), 32'd0);
        ticks(5, 3'b111);                       // R7: disabled timers ignore ticks
        rd(8'hFD, "R1"); rd(8'hFE, "R1"); rd(8'hFF, "R1");
        check("R7", 32'(m_out[0]), 32'd0);

        // R4: zero period gives 256 ticks per event
        wr(8'hFA, 8'h00, "R3");
        wr(8'hF1, 8'h81, "R2");
        ticks(255, 3'b001);
        rd(8'hFD, "R4");
        ticks(1, 3'b001);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'hFD, 3'b000, "R4");
        check("R4", 32'(rd_data), 32'd0);        // cleared by the previous read

        // R11: period lowered below the running count
        wr(8'hFB, 8'd10, "R3");
        wr(8'hF1, 8'h83, "R6");
        ticks(8, 3'b010);
        wr(8'hFB, 8'd4, "R3");
        ticks(247, 3'b010);
        rd(8'hFE, "R11");
        ticks(4, 3'b010);
        rd(8'hFE, "R11");

        // R8: read coinciding with an event keeps that event
        wr(8'hFC, 8'd1, "R3");
        wr(8'hF1, 8'h87, "R6");
        ticks(3, 3'b100);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'hFF, 3'b100, "R8");
        rd(8'hFF, "R8");
        rd(8'h12, "R8");

        // R6: repeated enable keeps state; R12: only own tick counts
        ticks(2, 3'b100);
        wr(8'hF1, 8'h87, "R6");
        rd(8'hFF, "R6");
        ticks(20, 3'b100);
        rd(8'hFD, "R12"); rd(8'hFE, "R12");
        ticks(17, 3'b100);                      // R5: 4-bit wrap past 15
        rd(8'hFF, "R5");

        // R7: disable freezes; R9/R10 clear pulses and select
        wr(8'hF1, 8'h30, "R9");
        ticks(6, 3'b111);
        rd(8'hFF, "R7");
        wr(8'hF1, 8'h10, "R9");
        wr(8'hF1, 8'hA0, "R10");

        // random traffic with a fixed seed
        void'($urandom(32'd20240607));
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a, d, ra;
            logic we, re;
            logic [2:0] tk;
            int sel = $urandom % 8;
            we = ($urandom % 4) == 0;
            re = ($urandom % 3) == 0;
            a  = (sel < 2) ? 8'hF1 : (sel < 7) ? 8'(8'hFA + ($urandom % 3)) : 8'h55;
            d  = (a == 8'hF1) ? 8'($urandom) : 8'($urandom % 9);
            ra = (($urandom % 5) == 0) ? 8'h20 : 8'(8'hFD + ($urandom % 3));
            tk = 3'($urandom);
            cyc(we, a, d, re, ra, tk, "R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule